// File: doc/BRIEF.md
# Locked System Control Register Bank

This block is a small memory-mapped register file for board-level system control. It sits on a simple 32-bit register bus inside a 4 KB window. Software reads an identification word whose board-type field comes from a strap parameter. It keeps two sets of software flags, each with separate set and clear addresses, and it can request a whole-system reset. The reset request is guarded: a write to the reset-control register is accepted only after a 16-bit key has been written to the lock register.

One flag set survives the soft reset that this block itself can trigger. The other flag set is cleared by every reset. A free-running counter advances at 24 MHz and can be read as a register. It is derived from the system clock by a fractional accumulator, so any system clock frequency at or above 24 MHz can be used. On boards whose type code is 0x190, the reset-control register is reserved. Any address without a defined register reads zero and ignores writes.

Top module: `sysctl_regbank`

## Requirements
- R1: After power-on reset, the lock (0x20), volatile flags (0x30), non-volatile flags (0x38) and reset control (0x40) all read 0, and `sys_reset_req` is low.
- R2: Offset 0x00 reads the `BOARD_ID` parameter. Bits 27:16 of that value are the 12-bit board-type field. Writes to 0x00 have no effect.
- R3: Writing 0xA05F to 0x20 stores 0xA05F and unlocks the block. Writing any other value stores only data bits 14:0, zero-extended, and leaves the block locked. Offset 0x20 reads back the stored value.
- R4: A write to 0x30 ORs the data into the volatile flags. A write to 0x34 clears the flag bits that are 1 in the data. Offset 0x30 reads the flags.
- R5: A write to 0x38 ORs the data into the non-volatile flags. A write to 0x3C clears the flag bits that are 1 in the data. Offset 0x38 reads the flags.
- R6: A write to 0x40 made while the lock holds 0xA05F stores data bits 7:0 as the reset level, which reads back at 0x40. A write to 0x40 made while locked changes nothing.
- R7: Each accepted write to 0x40 drives `sys_reset_req` high for the single cycle after the write edge.
- R8: A low pulse on `soft_rst_n` clears the lock, the volatile flags, the reset level and `sys_reset_req`, and keeps the non-volatile flags. A low pulse on `por_n` also clears the non-volatile flags.
- R9: When the board-type field equals 0x190, offset 0x40 reads 0, ignores writes and never raises `sys_reset_req`, even while the block is unlocked.
- R10: Offset 0x5C reads a tick count that advances by at most 1 per clock. At the defaults (100 MHz clock, 24 MHz tick), the count grows by exactly 6 over any 25 consecutive clocks.
- R11: Reads of undefined offsets (for example 0x0C and 0xA0) return 0. Writes to those offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, frequency `SYS_CLK_HZ` |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| soft_rst_n | input | 1 | Soft system reset, asynchronous, active low |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address within the window (word aligned) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The assertions assume that each bus write lasts exactly one clock. They also assume that a set address and the matching clear address are never written in the same cycle, which holds because the bus carries one address at a time. The bench drives every input at the falling edge and returns `bus_sel` low after each access. A second instance is strapped to board type 0x190 and shares the same bus, so both variants receive identical writes. The tick checks compare two reads taken exactly 25 clocks apart, so the result does not depend on the accumulator phase.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam logic [15:0] UNLOCK_KEY     = 16'hA05F;
  localparam logic [11:0] BT_RC_RESERVED = 12'h190;

  // word offsets (byte offset / 4)
  localparam int W_ID     = 'h00;
  localparam int W_LOCK   = 'h08;
  localparam int W_VSET   = 'h0C;
  localparam int W_VCLR   = 'h0D;
  localparam int W_NVSET  = 'h0E;
  localparam int W_NVCLR  = 'h0F;
  localparam int W_RSTCTL = 'h10;
  localparam int W_TICK   = 'h17;

  function automatic logic [11:0] board_type(input logic [31:0] id);
    return id[27:16];
  endfunction

  function automatic logic [15:0] lock_store(input logic [15:0] d);
    return (d == UNLOCK_KEY) ? UNLOCK_KEY : {1'b0, d[14:0]};
  endfunction

  function automatic logic [31:0] flag_update(input logic [31:0] cur, input logic [31:0] d,
                                              input logic set_w, input logic clr_w);
    logic [31:0] r;
    r = cur;
    if (set_w) r = r | d;
    if (clr_w) r = r & ~d;
    return r;
  endfunction

  // returns {carry, next accumulator}
  function automatic logic [32:0] tick_next(input logic [31:0] acc, input logic [31:0] step,
                                            input logic [31:0] modulus);
    logic [32:0] sum;
    sum = {1'b0, acc} + {1'b0, step};
    if (sum >= {1'b0, modulus}) return {1'b1, 32'(sum - {1'b0, modulus})};
    return {1'b0, sum[31:0]};
  endfunction

endpackage

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic [15:0] lockval,
  output logic        unlocked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  lockval <= '0;
    else if (wr) lockval <= lock_store(wdata);
  end

  assign unlocked = (lockval == UNLOCK_KEY);

  // R3
  a_r3_key_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata == UNLOCK_KEY) |=> unlocked);
  a_r3_other_locks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata != UNLOCK_KEY) |=> (!unlocked && lockval[15] == 1'b0));
endmodule

// File: rtl/sysctl_flags.sv
module sysctl_flags
  import sysctl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic         clr_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= W'(flag_update(32'(flags), 32'(wdata), set_wr, clr_wr));
  end

  // R4 / R5: set and clear act on exactly the data bits
  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wr && !clr_wr) |=> ((flags & $past(wdata)) == $past(wdata)));
  a_r4_flag_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !set_wr) |=> ((flags & $past(wdata)) == '0));
  a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_wr && !clr_wr) |=> $stable(flags));
endmodule

// File: rtl/sysctl_tick.sv
module sysctl_tick
  import sysctl_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 100_000_000,
  parameter int unsigned TICK_HZ    = 24_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [31:0] count
);
  localparam logic [31:0] STEP = 32'(TICK_HZ);
  localparam logic [31:0] MODV = 32'(SYS_CLK_HZ);

  logic [31:0] acc;
  logic [32:0] nxt;
  logic        tick_evt;

  assign nxt      = tick_next(acc, STEP, MODV);
  assign tick_evt = nxt[32];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      count <= '0;
    end else begin
      acc <= nxt[31:0];
      if (tick_evt) count <= count + 32'd1;
    end
  end

  // R10
  a_r10_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 32'd1));
  a_r10_acc_range: assert property (@(posedge clk) disable iff (!rst_n)
    acc < MODV);
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter logic [31:0] BOARD_ID   = 32'h0178_0000,
  parameter int unsigned SYS_CLK_HZ = 100_000_000,
  parameter int unsigned TICK_HZ    = 24_000_000,
  parameter int          ADDR_W     = 12,
  parameter int          RST_LVL_W  = 8
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              soft_rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              sys_reset_req
);
  localparam int  WI_W        = ADDR_W - 2;
  localparam bit  RC_RESERVED = (board_type(BOARD_ID) == BT_RC_RESERVED);

  logic [WI_W-1:0] word_idx;
  logic            wr, rst_any_n;
  logic [15:0]     lockval;
  logic            unlocked;
  logic [31:0]     vflags, nvflags, tick_cnt;
  logic [RST_LVL_W-1:0] rst_lvl;
  logic            rc_wr, rc_accept;
  logic            unused_addr;

  assign unused_addr = ^bus_addr[1:0];
  assign word_idx    = bus_addr[ADDR_W-1:2];
  assign wr          = bus_sel && bus_we;
  assign rst_any_n   = por_n && soft_rst_n;
  assign rc_wr       = wr && int'(word_idx) == W_RSTCTL;

  sysctl_lock u_lock (
    .clk(clk), .rst_n(rst_any_n),
    .wr(wr && int'(word_idx) == W_LOCK), .wdata(bus_wdata[15:0]),
    .lockval(lockval), .unlocked(unlocked)
  );

  sysctl_flags #(.W(32)) u_vflags (
    .clk(clk), .rst_n(rst_any_n),
    .set_wr(wr && int'(word_idx) == W_VSET), .clr_wr(wr && int'(word_idx) == W_VCLR),
    .wdata(bus_wdata), .flags(vflags)
  );

  sysctl_flags #(.W(32)) u_nvflags (
    .clk(clk), .rst_n(por_n),
    .set_wr(wr && int'(word_idx) == W_NVSET), .clr_wr(wr && int'(word_idx) == W_NVCLR),
    .wdata(bus_wdata), .flags(nvflags)
  );

  sysctl_tick #(.SYS_CLK_HZ(SYS_CLK_HZ), .TICK_HZ(TICK_HZ)) u_tick (
    .clk(clk), .rst_n(por_n), .count(tick_cnt)
  );

  generate
    if (RC_RESERVED) begin : g_rc_reserved
      assign rc_accept     = 1'b0;
      assign rst_lvl       = '0;
      assign sys_reset_req = 1'b0;
    end else begin : g_rc_active
      logic [RST_LVL_W-1:0] lvl_q;
      logic                 req_q;
      assign rc_accept = rc_wr && unlocked;
      always_ff @(posedge clk or negedge rst_any_n) begin
        if (!rst_any_n) begin
          lvl_q <= '0;
          req_q <= 1'b0;
        end else begin
          req_q <= rc_accept;
          if (rc_accept) lvl_q <= bus_wdata[RST_LVL_W-1:0];
        end
      end
      assign rst_lvl       = lvl_q;
      assign sys_reset_req = req_q;

      // R6: a locked write leaves the level unchanged
      a_r6_locked_hold: assert property (@(posedge clk) disable iff (!rst_any_n)
        (rc_wr && !unlocked) |=> $stable(lvl_q));
    end
  endgenerate

  always_comb begin
    case (int'(word_idx))
      W_ID:     bus_rdata = BOARD_ID;
      W_LOCK:   bus_rdata = {16'h0, lockval};
      W_VSET:   bus_rdata = vflags;
      W_NVSET:  bus_rdata = nvflags;
      W_RSTCTL: bus_rdata = 32'(rst_lvl);
      W_TICK:   bus_rdata = tick_cnt;
      default:  bus_rdata = '0;
    endcase
  end

  // R7: a request follows only an unlocked write to reset control
  a_r7_req_source: assert property (@(posedge clk) disable iff (!rst_any_n)
    sys_reset_req |-> $past(rc_wr && unlocked));
  a_r7_req_follows: assert property (@(posedge clk) disable iff (!rst_any_n)
    rc_accept |=> sys_reset_req);
  // R9: reserved variant never requests
  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_any_n)
    (RC_RESERVED && rc_wr) |=> !sys_reset_req);
endmodule

// File: tb/test_sysctl_regbank.sv
module test_sysctl_regbank;
  localparam logic [31:0] ID_MAIN = 32'h0178_0A5C;
  localparam logic [31:0] ID_VX   = 32'h0190_0000;

  logic clk = 0;
  logic por_n = 0, soft_rst_n = 1;
  logic bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata_m, rdata_v;
  logic req_m, req_v;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sysctl_regbank #(.BOARD_ID(ID_MAIN)) i_sysctl_regbank (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .sys_reset_req(req_m));

  sysctl_regbank #(.BOARD_ID(ID_VX)) i_vx (
    .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_v), .sys_reset_req(req_v));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] dm, output logic [31:0] dv);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    dm = rdata_m; dv = rdata_v;
    bus_sel = 0;
  endtask

  task automatic t_reset_state();
    logic [31:0] m, v;
    rd(12'h020, m, v); chk("R1 lock", m, 0);
    rd(12'h030, m, v); chk("R1 vflags", m, 0);
    rd(12'h038, m, v); chk("R1 nvflags", m, 0);
    rd(12'h040, m, v); chk("R1 rstctl", m, 0);
    chk("R1 req", {31'b0, req_m}, 0);
  endtask

  task automatic t_id();
    logic [31:0] m, v;
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, m, v); chk("R2 id main", m, ID_MAIN); chk("R2 id vx", v, ID_VX);
  endtask

  task automatic t_lock();
    logic [31:0] m, v;
    wr(12'h020, 32'h1234_FFFF);
    rd(12'h020, m, v); chk("R3 non-key", m, 32'h0000_7FFF);
    wr(12'h020, 32'h0000_A05F);
    rd(12'h020, m, v); chk("R3 key", m, 32'h0000_A05F);
    wr(12'h020, 32'h0000_A05E);
    rd(12'h020, m, v); chk("R3 relock", m, 32'h0000_205E);
  endtask

  task automatic t_flags();
    logic [31:0] m, v;
    wr(12'h030, 32'h0000_00F0); wr(12'h030, 32'h8000_0001);
    rd(12'h030, m, v); chk("R4 set or", m, 32'h8000_00F1);
    wr(12'h034, 32'h8000_0030);
    rd(12'h030, m, v); chk("R4 clr", m, 32'h0000_00C1);
    rd(12'h038, m, v); chk("R5 untouched", m, 0);
    wr(12'h038, 32'h5A5A_0000); wr(12'h03C, 32'h0A00_0000);
    rd(12'h038, m, v); chk("R5 set clr", m, 32'h505A_0000);
    rd(12'h030, m, v); chk("R4 untouched", m, 32'h0000_00C1);
  endtask

  task automatic t_rstctl();
    logic [31:0] m, v;
    wr(12'h020, 32'h0);
    wr(12'h040, 32'h0000_0033);
    chk("R7 locked no req", {31'b0, req_m}, 0);
    rd(12'h040, m, v); chk("R6 locked ignored", m, 0);
    wr(12'h020, 32'hA05F);
    wr(12'h040, 32'hFFFF_FF5A);
    chk("R7 req high", {31'b0, req_m}, 1);
    chk("R9 vx no req", {31'b0, req_v}, 0);
    @(negedge clk);
    chk("R7 req one cycle", {31'b0, req_m}, 0);
    rd(12'h040, m, v); chk("R6 level", m, 32'h5A); chk("R9 vx reads 0", v, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] m, v;
    @(negedge clk); soft_rst_n = 0;
    @(negedge clk); soft_rst_n = 1;
    rd(12'h020, m, v); chk("R8 lock cleared", m, 0);
    rd(12'h030, m, v); chk("R8 vflags cleared", m, 0);
    rd(12'h040, m, v); chk("R8 level cleared", m, 0);
    rd(12'h038, m, v); chk("R8 nvflags kept", m, 32'h505A_0000);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    rd(12'h038, m, v); chk("R8 por clears nv", m, 0);
  endtask

  task automatic t_undef();
    logic [31:0] m, v;
    wr(12'h030, 32'h0000_0011);
    wr(12'h00C, 32'hFFFF_FFFF); wr(12'h0A0, 32'hFFFF_FFFF); wr(12'h0A4, 32'hFFFF_FFFF);
    rd(12'h00C, m, v); chk("R11 0x0C", m, 0);
    rd(12'h0A0, m, v); chk("R11 0xA0", m, 0);
    rd(12'h030, m, v); chk("R11 no side effect", m, 32'h11);
    rd(12'h020, m, v); chk("R11 lock intact", m, 0);
  endtask

  task automatic t_tick();
    logic [31:0] a, b, v;
    @(negedge clk); rd(12'h05C, a, v);
    repeat (25) @(negedge clk);
    rd(12'h05C, b, v); chk("R10 6 per 25", b - a, 6);
    repeat (7) @(negedge clk);
    rd(12'h05C, a, v);
    repeat (25) @(negedge clk);
    rd(12'h05C, b, v); chk("R10 6 per 25 shifted", b - a, 6);
    repeat (250) @(negedge clk);
    rd(12'h05C, a, v); chk("R10 advancing", {31'b0, a > b}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    t_reset_state();
    t_id();
    t_lock();
    t_flags();
    t_rstctl();
    t_soft_reset();
    t_undef();
    t_tick();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule